// File: doc/BRIEF.md
# Strap-Configured Clock Output Controller

This block decides, once per power-on, which clock each output group of a clock generator drives. While the active-low power-on reset `por_n` is held, four shared pads act as inputs. Their levels are captured on every reference-clock rising edge into a 4-bit configuration register. One bit selects the bus-clock style. The other three form a frequency-select code. When reset is released, the pads become outputs and carry clocks alongside the dedicated output groups. The PLL, the oscillator and the pad drivers are outside the block. The synthesizer clocks reach it as plain input clocks.

The captured code chooses a source for each group. In normal operation the CPU group copies the synthesizer CPU clock, and the 48 MHz output copies the USB synthesizer clock. The 24 MHz output is that clock divided by two. The bus group runs either at half the CPU clock (synchronous) or from a free-running asynchronous input. Code 011 is a production test mode that feeds every group from divided copies of the reference clock. Code 111 parks every output in high impedance.

A small state machine sequences this. `ST_SAMPLE` is entered asynchronously whenever `por_n` is low. On the first reference edge with `por_n` high it moves to `ST_PARK` if the code is 111, and to `ST_DRIVE` otherwise. Both `ST_DRIVE` and `ST_PARK` hold until the next reset, so the code is never read again.

Top module: `strap_clk_ctrl`

## Requirements
- R1: While `por_n` is low, every pad enable (`pad_oe_o`) and every group enable (`cpu_oe_o`, `bus_oe_o`, `fix_oe_o`) is 0, and all clock outputs are 0.
- R2: The strap value is the level of `pad_i` at the last reference rising edge with `por_n` low. `pad_i[0]` is bus-select and `pad_i[3:1]` is the select code {FS2,FS1,FS0}. Changes on `pad_i` after release have no effect on any output.
- R3: For codes other than 111, all enables are 0 before the first reference rising edge after `por_n` goes high, rise on that edge, and stay high until reset.
- R4: Code 111 keeps all enables at 0 and all clock outputs at 0 after release.
- R5: In normal codes (neither 011 nor 111), the CPU group (`cpu_o` and `pad_o[3:1]`) copies `cpu_syn_clk`. `f48_o` copies `usb_syn_clk`, and `f24_o` runs at half the `usb_syn_clk` frequency with 50% duty.
- R6: In normal codes, bus-select 1 gives bus outputs at half the `cpu_syn_clk` frequency, and bus-select 0 gives bus outputs that copy `bus_async_clk`.
- R7: In test code 011, the CPU group and `f48_o` run at the reference frequency divided by 2, and `f24_o` at the reference divided by 4, all with 50% duty.
- R8: In test code 011, bus outputs run at the reference divided by 4 when bus-select is 1. When bus-select is 0 they run at the reference divided by 3 and are high for 1.5 reference periods.
- R9: `pad_o[0]` carries the reference clock in every code except 111.
- R10: All members of a group (every `cpu_o` bit and `pad_o[3:1]`; every `bus_o` bit) carry the same waveform.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock; clocks the state machine, capture register and test dividers |
| por_n | input | 1 | Power-on reset, active low, asynchronous assert |
| cpu_syn_clk | input | 1 | Synthesizer CPU-rate clock |
| bus_async_clk | input | 1 | Free-running asynchronous bus clock |
| usb_syn_clk | input | 1 | Synthesizer 48 MHz clock |
| pad_i | input | 4 | Shared pad levels; [0] bus-select, [3:1] select code |
| pad_o | output | 4 | Shared pad clocks after reset; [0] reference, [3:1] CPU group |
| pad_oe_o | output | 4 | Shared pad output enables |
| cpu_o | output | NUM_CPU-3 | Dedicated CPU group clocks |
| cpu_oe_o | output | 1 | CPU group enable |
| bus_o | output | NUM_BUS | Bus group clocks |
| bus_oe_o | output | 1 | Bus group enable |
| f48_o | output | 1 | 48 MHz output |
| f24_o | output | 1 | 24 MHz output |
| fix_oe_o | output | 1 | Enable for the 48/24 MHz outputs |

## Verification
The enables are due exactly one reference edge after `por_n` rises. The bench releases reset 2 ns after a reference edge and samples the enables twice: once before the next edge, where they must be 0, and once 2 ns after it, where they must be 1. The reference-domain dividers start on the edge after the enables. The half-rate dividers in the CPU and USB domains start two to three of their own clock edges later, behind their reset synchronizers. The bench therefore waits six reference periods before measuring any period. Periods and high times are taken from rising and falling edges polled on a half-nanosecond grid offset from every clock edge. Each expected period comes from the captured code and the known input clock periods.

// File: rtl/strapclk_pkg.sv
`timescale 1ns/1ps
package strapclk_pkg;

    typedef enum logic [1:0] {
        ST_SAMPLE = 2'b00,
        ST_DRIVE  = 2'b01,
        ST_PARK   = 2'b10
    } ctl_state_e;

    typedef enum logic [1:0] {
        MODE_OFF  = 2'b00,
        MODE_NORM = 2'b01,
        MODE_TEST = 2'b10
    } clk_mode_e;

    typedef struct packed {
        logic [2:0] fs;
        logic       bsel;
    } strap_t;

    localparam int          STRAP_W = $bits(strap_t);
    localparam logic [2:0]  FS_TEST = 3'b011;
    localparam logic [2:0]  FS_OFF  = 3'b111;

endpackage

// File: rtl/strap_ctl_fsm.sv
`timescale 1ns/1ps
module strap_ctl_fsm
    import strapclk_pkg::*;
(
    input  logic               ref_clk,
    input  logic               por_n,
    input  logic [STRAP_W-1:0] strap_i,
    output strap_t             cfg_o,
    output logic               drive_o,
    output clk_mode_e          mode_o
);

    ctl_state_e state_q, state_d;
    strap_t     cfg_q;

    // capture straps only on edges seen while reset is asserted
    always_ff @(posedge ref_clk) begin
        if (!por_n) begin
            cfg_q <= strap_t'(strap_i);
        end
    end

    always_ff @(posedge ref_clk or negedge por_n) begin
        if (!por_n) begin
            state_q <= ST_SAMPLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SAMPLE: state_d = (cfg_q.fs == FS_OFF) ? ST_PARK : ST_DRIVE;
            ST_DRIVE:  state_d = ST_DRIVE;
            ST_PARK:   state_d = ST_PARK;
            default:   state_d = ST_SAMPLE;
        endcase
    end

    always_comb begin
        drive_o = 1'b0;
        mode_o  = MODE_OFF;
        unique case (state_q)
            ST_DRIVE: begin
                drive_o = 1'b1;
                mode_o  = (cfg_q.fs == FS_TEST) ? MODE_TEST : MODE_NORM;
            end
            ST_SAMPLE, ST_PARK: begin
                drive_o = 1'b0;
                mode_o  = MODE_OFF;
            end
            default: begin
                drive_o = 1'b0;
                mode_o  = MODE_OFF;
            end
        endcase
    end

    assign cfg_o = cfg_q;

    // R2: configuration frozen once sampling is over
    a_r2_cfg_frozen: assert property (@(posedge ref_clk) disable iff (!por_n)
        (state_q != ST_SAMPLE) |=> $stable(cfg_q));

    // R3: sampling state left on the first edge after release
    a_r3_leave_sample: assert property (@(posedge ref_clk) disable iff (!por_n)
        (state_q == ST_SAMPLE) |=> (state_q != ST_SAMPLE));

    // R4: the all-off code always ends parked
    a_r4_off_parks: assert property (@(posedge ref_clk) disable iff (!por_n)
        (state_q != ST_SAMPLE && cfg_q.fs == FS_OFF) |-> (state_q == ST_PARK));

endmodule

// File: rtl/strap_rst_sync.sv
`timescale 1ns/1ps
module strap_rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    output logic rst_no
);

    logic [STAGES-1:0] sh_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sh_q <= '0;
        end else begin
            sh_q <= {sh_q[STAGES-2:0], 1'b1};
        end
    end

    assign rst_no = sh_q[STAGES-1];

endmodule

// File: rtl/strap_clk_div.sv
`timescale 1ns/1ps
module strap_clk_div #(
    parameter int DIV = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    output logic clk_o
);

    localparam int CW     = (DIV <= 2) ? 1 : $clog2(DIV);
    localparam int HI_CYC = DIV / 2;

    logic [CW-1:0] cnt_q, cnt_d;
    logic          pos_q;

    assign cnt_d = (cnt_q == CW'(DIV - 1)) ? '0 : cnt_q + 1'b1;

    // counter parked at its last value so the first edge starts a high phase
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= CW'(DIV - 1);
            pos_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            pos_q <= (cnt_d < CW'(HI_CYC));
        end
    end

    generate
        if (DIV % 2 == 1) begin : g_odd
            logic neg_q;
            // half-cycle stretch on the falling edge gives 50% duty
            always_ff @(negedge clk_i or negedge rst_ni) begin
                if (!rst_ni) begin
                    neg_q <= 1'b0;
                end else begin
                    neg_q <= pos_q;
                end
            end
            assign clk_o = pos_q | neg_q;
        end else begin : g_even
            assign clk_o = pos_q;
        end
    endgenerate

    // R8: divider count stays inside its modulus
    a_r8_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_q <= CW'(DIV - 1));

endmodule

// File: rtl/strap_clk_ctrl.sv
`timescale 1ns/1ps
module strap_clk_ctrl
    import strapclk_pkg::*;
#(
    parameter  int NUM_CPU    = 12,
    parameter  int NUM_BUS    = 6,
    localparam int SHARED_CPU = 3,
    localparam int CPU_DED    = NUM_CPU - SHARED_CPU
) (
    input  logic               ref_clk,
    input  logic               por_n,
    input  logic               cpu_syn_clk,
    input  logic               bus_async_clk,
    input  logic               usb_syn_clk,
    input  logic [STRAP_W-1:0] pad_i,
    output logic [STRAP_W-1:0] pad_o,
    output logic [STRAP_W-1:0] pad_oe_o,
    output logic [CPU_DED-1:0] cpu_o,
    output logic               cpu_oe_o,
    output logic [NUM_BUS-1:0] bus_o,
    output logic               bus_oe_o,
    output logic               f48_o,
    output logic               f24_o,
    output logic               fix_oe_o
);

    strap_t    cfg;
    logic      drive;
    clk_mode_e mode;
    logic [4:2] ref_div;
    logic      cpu_rst_n, usb_rst_n;
    logic      bus_sync_clk, usb_half_clk;
    logic      cpu_src, bus_src, f48_src, f24_src, ref_src, grp_oe;

    strap_ctl_fsm u_fsm (
        .ref_clk (ref_clk),
        .por_n   (por_n),
        .strap_i (pad_i),
        .cfg_o   (cfg),
        .drive_o (drive),
        .mode_o  (mode)
    );

    // reference dividers for test mode: /2, /3, /4
    for (genvar d = 2; d <= 4; d++) begin : g_ref_div
        strap_clk_div #(.DIV(d)) u_div (
            .clk_i  (ref_clk),
            .rst_ni (drive),
            .clk_o  (ref_div[d])
        );
    end

    strap_rst_sync #(.STAGES(2)) u_cpu_rst (
        .clk_i  (cpu_syn_clk),
        .rst_ni (drive),
        .rst_no (cpu_rst_n)
    );

    strap_clk_div #(.DIV(2)) u_bus_half (
        .clk_i  (cpu_syn_clk),
        .rst_ni (cpu_rst_n),
        .clk_o  (bus_sync_clk)
    );

    strap_rst_sync #(.STAGES(2)) u_usb_rst (
        .clk_i  (usb_syn_clk),
        .rst_ni (drive),
        .rst_no (usb_rst_n)
    );

    strap_clk_div #(.DIV(2)) u_usb_half (
        .clk_i  (usb_syn_clk),
        .rst_ni (usb_rst_n),
        .clk_o  (usb_half_clk)
    );

    always_comb begin
        cpu_src = 1'b0;
        bus_src = 1'b0;
        f48_src = 1'b0;
        f24_src = 1'b0;
        ref_src = 1'b0;
        grp_oe  = 1'b0;
        unique case (mode)
            MODE_NORM: begin
                cpu_src = cpu_syn_clk;
                bus_src = cfg.bsel ? bus_sync_clk : bus_async_clk;
                f48_src = usb_syn_clk;
                f24_src = usb_half_clk;
                ref_src = ref_clk;
                grp_oe  = 1'b1;
            end
            MODE_TEST: begin
                cpu_src = ref_div[2];
                bus_src = cfg.bsel ? ref_div[4] : ref_div[3];
                f48_src = ref_div[2];
                f24_src = ref_div[4];
                ref_src = ref_clk;
                grp_oe  = 1'b1;
            end
            MODE_OFF: begin
                grp_oe  = 1'b0;
            end
            default: begin
                grp_oe  = 1'b0;
            end
        endcase
    end

    assign cpu_o    = {CPU_DED{cpu_src}};
    assign bus_o    = {NUM_BUS{bus_src}};
    assign f48_o    = f48_src;
    assign f24_o    = f24_src;
    assign pad_o    = {{SHARED_CPU{cpu_src}}, ref_src};
    assign pad_oe_o = {STRAP_W{grp_oe}};
    assign cpu_oe_o = grp_oe;
    assign bus_oe_o = grp_oe;
    assign fix_oe_o = grp_oe;

    // R1: pads stay inputs while reset is held
    always_ff @(posedge ref_clk) begin
        if (!por_n) begin
            a_r1_pads_input: assert (pad_oe_o == '0 && !cpu_oe_o && !bus_oe_o && !fix_oe_o);
        end
    end

    // R3: once enabled, outputs stay enabled until reset
    a_r3_oe_hold: assert property (@(posedge ref_clk) disable iff (!por_n)
        pad_oe_o[0] |=> pad_oe_o[0]);

endmodule

// File: tb/test_strap_clk_ctrl.sv
`timescale 1ns/1ps
module test_strap_clk_ctrl;

    localparam int NUM_CPU = 12;
    localparam int NUM_BUS = 6;
    localparam int CPU_DED = NUM_CPU - 3;

    logic ref_clk = 1'b0, cpu_syn_clk = 1'b0, bus_async_clk = 1'b0, usb_syn_clk = 1'b0;
    logic por_n = 1'b0;
    logic [3:0] pad_drv = 4'b0000;
    logic [3:0] pad_o, pad_oe_o;
    logic [CPU_DED-1:0] cpu_o;
    logic [NUM_BUS-1:0] bus_o;
    logic cpu_oe_o, bus_oe_o, f48_o, f24_o, fix_oe_o;

    always #5  ref_clk       = ~ref_clk;
    always #6  cpu_syn_clk   = ~cpu_syn_clk;
    always #16 bus_async_clk = ~bus_async_clk;
    always #9  usb_syn_clk   = ~usb_syn_clk;

    strap_clk_ctrl #(.NUM_CPU(NUM_CPU), .NUM_BUS(NUM_BUS)) i_strap_clk_ctrl (
        .ref_clk(ref_clk), .por_n(por_n), .cpu_syn_clk(cpu_syn_clk),
        .bus_async_clk(bus_async_clk), .usb_syn_clk(usb_syn_clk),
        .pad_i(pad_drv), .pad_o(pad_o), .pad_oe_o(pad_oe_o),
        .cpu_o(cpu_o), .cpu_oe_o(cpu_oe_o), .bus_o(bus_o), .bus_oe_o(bus_oe_o),
        .f48_o(f48_o), .f24_o(f24_o), .fix_oe_o(fix_oe_o)
    );

    typedef struct {
        int    sig;
        real   per;
        real   hi;
        bit    oe;
        string req;
    } exp_t;

    exp_t q[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   busy  = 1'b0;

    task automatic chk(bit ok, string req, string what, real act, real exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0.2f expected %0.2f", req, what, act, exp);
        end
    endtask

    function automatic logic sig_val(int id);
        case (id)
            0: return cpu_o[0];
            1: return cpu_o[CPU_DED-1];
            2: return bus_o[0];
            3: return bus_o[NUM_BUS-1];
            4: return f48_o;
            5: return f24_o;
            6: return pad_o[0];
            7: return pad_o[1];
            default: return pad_o[3];
        endcase
    endfunction

    function automatic logic sig_oe(int id);
        case (id)
            0, 1: return cpu_oe_o;
            2, 3: return bus_oe_o;
            4, 5: return fix_oe_o;
            6: return pad_oe_o[0];
            7: return pad_oe_o[1];
            default: return pad_oe_o[3];
        endcase
    endfunction

    // polling on a 0.5 ns grid offset by 0.25 ns from all clock edges
    task automatic wait_level(int id, logic lvl, output bit ok);
        ok = 1'b0;
        for (int k = 0; k < 200; k++) begin
            if (sig_val(id) === lvl) begin
                ok = 1'b1;
                break;
            end
            #0.5;
        end
    endtask

    task automatic measure(int id, output real per, output real hi);
        bit ok;
        real t1, tf;
        per = 0.0;
        hi  = 0.0;
        wait_level(id, 1'b0, ok);
        if (!ok) return;
        wait_level(id, 1'b1, ok);
        if (!ok) return;
        t1 = $realtime;
        wait_level(id, 1'b0, ok);
        if (!ok) return;
        tf = $realtime;
        wait_level(id, 1'b1, ok);
        if (!ok) return;
        per = $realtime - t1;
        hi  = tf - t1;
    endtask

    // monitor: pops expected items and compares against measured waveforms
    initial begin
        exp_t e;
        real per, hi;
        #0.25;
        forever begin
            while (q.size() == 0) #0.5;
            busy = 1'b1;
            e = q.pop_front();
            chk(sig_oe(e.sig) == e.oe, e.req, $sformatf("enable sig%0d", e.sig),
                real'(sig_oe(e.sig)), real'(e.oe));
            measure(e.sig, per, hi);
            chk((per - e.per) < 0.1 && (e.per - per) < 0.1, e.req,
                $sformatf("period sig%0d", e.sig), per, e.per);
            chk((hi - e.hi) < 0.1 && (e.hi - hi) < 0.1, e.req,
                $sformatf("high time sig%0d", e.sig), hi, e.hi);
            if (e.per == 0.0) begin
                chk(sig_val(e.sig) === 1'b0, e.req, $sformatf("parked level sig%0d", e.sig),
                    real'(sig_val(e.sig)), 0.0);
            end
            busy = 1'b0;
        end
    end

    task automatic push(int sig, real per, bit oe, string req);
        exp_t e;
        e.sig = sig;
        e.per = per;
        e.hi  = per / 2.0;
        e.oe  = oe;
        e.req = req;
        q.push_back(e);
    endtask

    // driver: one power-on sequence per strap value
    task automatic run_code(logic [3:0] straps);
        logic [2:0] fs;
        bit off, tst, bsel;
        real cpu_p, bus_p, f48_p, f24_p, ref_p;
        fs   = straps[3:1];
        bsel = straps[0];
        off  = (fs == 3'b111);
        tst  = (fs == 3'b011);
        por_n   = 1'b0;
        pad_drv = straps;
        repeat (4) @(posedge ref_clk);
        #2;
        // R1: pads inputs and outputs quiet in reset
        chk(pad_oe_o == 4'b0 && !cpu_oe_o && !bus_oe_o && !fix_oe_o, "R1", "enables in reset",
            real'(pad_oe_o), 0.0);
        chk(pad_o == 4'b0 && cpu_o == '0 && bus_o == '0 && !f48_o && !f24_o, "R1",
            "outputs in reset", real'(pad_o), 0.0);
        por_n = 1'b1;
        #2;
        // R3: not yet enabled before the first edge after release
        chk(pad_oe_o == 4'b0, "R3", "enable before first edge", real'(pad_oe_o), 0.0);
        @(posedge ref_clk);
        #2;
        chk(pad_oe_o == (off ? 4'b0000 : 4'b1111), "R3", "enable after first edge",
            real'(pad_oe_o), off ? 0.0 : 15.0);
        // R2: straps changed after release must be ignored
        pad_drv = ~straps;
        repeat (6) @(posedge ref_clk);
        #0.25;
        cpu_p = off ? 0.0 : (tst ? 20.0 : 12.0);
        bus_p = off ? 0.0 : (tst ? (bsel ? 40.0 : 30.0) : (bsel ? 24.0 : 32.0));
        f48_p = off ? 0.0 : (tst ? 20.0 : 18.0);
        f24_p = off ? 0.0 : (tst ? 40.0 : 36.0);
        ref_p = off ? 0.0 : 10.0;
        push(0, cpu_p, !off, off ? "R4" : (tst ? "R7/R2" : "R5/R2"));
        push(1, cpu_p, !off, off ? "R4" : "R10");
        push(2, bus_p, !off, off ? "R4" : (tst ? "R8/R2" : "R6/R2"));
        push(3, bus_p, !off, off ? "R4" : "R10");
        push(4, f48_p, !off, off ? "R4" : (tst ? "R7" : "R5"));
        push(5, f24_p, !off, off ? "R4" : (tst ? "R7" : "R5"));
        push(6, ref_p, !off, off ? "R4" : "R9");
        push(7, cpu_p, !off, off ? "R4" : "R10");
        push(8, cpu_p, !off, off ? "R4" : "R10");
        #1;
        while (q.size() != 0 || busy) #1;
    endtask

    initial begin
        for (int c = 0; c < 16; c++) begin
            run_code(4'(c));
        end
        // back-to-back reset into the test code after a parked run
        run_code(4'b1111);
        run_code(4'b0110);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #1_500_000;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule